// File: doc/BRIEF.md
# Streaming 3x3 Gaussian Smoothing Filter

This block smooths an 8-bit greyscale image that arrives as a raster-order pixel stream, one pixel per clock at most. Two line stores hold the previous two image rows, and a 3x3 register window exposes all nine neighbours of the current centre pixel in a single cycle. The weighted sum uses the fixed kernel with outer rows weighted 1,2,1 and a centre row weighted 2,4,2. Each row is formed by shifts and adds, with no multiplier. The total is divided by 16 with rounding.

A small control state machine counts the row and column of every accepted pixel. It marks which windows lie wholly inside the frame and carries that mark down a valid pipeline that is as deep as the arithmetic. Frames follow one another without any gap: the counters wrap after the last pixel of a frame. Border centres produce no output, so an H x W frame yields (H-2) x (W-2) results.

Top module: `gauss3x3_stream`

## Requirements
- R1: A synchronous active-high reset clears the window, the position counters and the valid pipeline. After reset `out_valid` is 0, and the next accepted pixel is treated as row 0, column 0 of a new frame.
- R2: `in_ready` is 1 whenever `rst` is 0 and 0 while `rst` is 1. A pixel is accepted on a rising edge where `in_valid` and `in_ready` are both 1.
- R3: Each output equals (S + 8) >> 4. S is the sum of the 3x3 neighbourhood weighted 1 2 1 / 2 4 2 / 1 2 1, and the centre carries weight 4.
- R4: An output is produced only for centres at row 1..H-2 and column 1..W-2, in raster order. A full frame gives exactly (H-2)(W-2) outputs.
- R5: The output for the window completed by a pixel accepted on rising edge k is presented with `out_valid` = 1 after rising edge k+2, for exactly one cycle.
- R6: The accumulator cannot overflow. A frame of all 255 gives outputs of 255, and a frame of all 0 gives outputs of 0.
- R7: Cycles with `in_valid` = 0 have no effect: the `in_pix` value in those cycles never enters the result, and the outputs equal those of the same frame sent with no gaps.
- R8: Frames sent back to back are filtered independently. The counters wrap after H*W accepted pixels, and no output mixes pixels of two frames.
- R9: With an input pixel in every cycle, the outputs of one image row appear on W-2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | PIX_W | Input pixel, raster order |
| out_valid | output | 1 | Filtered pixel present |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
In any one cycle, a new pixel can be loaded into the window and line stores while an earlier window's row sums are normalised into an output. The bench drives full-rate frames, frames with random stalls and frames sent back to back, so the window shifts in the same cycle that the normaliser emits. Every output is compared with a frame model computed arithmetically in the bench. Each output is also checked for the exact cycle it is due, which catches an output lost or duplicated when the shifts and the emits overlap, including across a frame boundary and a reset in mid-frame.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
    // Control phase: filling the first two rows, or producing windows
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Kernel weights sum to 16 -> shift by 4, round by adding half
    localparam int KERNEL_SHIFT = 4;
    localparam int ROUND_BIAS   = 1 << (KERNEL_SHIFT - 1);
    localparam int KERNEL_SIZE  = 3;

    // Largest weighted sum for a given pixel width
    function automatic int max_weighted_sum(input int pix_w);
        return ((1 << pix_w) - 1) << KERNEL_SHIFT;
    endfunction
endpackage

// File: rtl/gauss_ctrl.sv
module gauss_ctrl
    import gauss_pkg::*;
#(
    parameter int IMG_W = 10,
    parameter int IMG_H = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          accept,
    output logic [$clog2(IMG_W)-1:0]      col,
    output logic [$clog2(IMG_H)-1:0]      row,
    output logic                          win_vld,
    output logic                          sum_vld,
    output logic                          out_vld
);
    localparam int COL_W = $clog2(IMG_W);
    localparam int ROW_W = $clog2(IMG_H);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);
    localparam logic [COL_W-1:0] COL_FIRST_FULL = COL_W'(KERNEL_SIZE - 1);
    localparam logic [ROW_W-1:0] ROW_ENTER_RUN  = ROW_W'(KERNEL_SIZE - 2);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            col     <= '0;
            row     <= '0;
            phase   <= PH_FILL;
            win_vld <= 1'b0;
            sum_vld <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            win_vld <= accept && (phase == PH_RUN) && (col >= COL_FIRST_FULL);
            sum_vld <= win_vld;
            out_vld <= sum_vld;
            if (accept) begin
                if (col == COL_LAST) begin
                    col <= '0;
                    if (row == ROW_LAST) begin
                        row   <= '0;
                        phase <= PH_FILL;
                    end else begin
                        row <= row + 1'b1;
                        if (row == ROW_ENTER_RUN)
                            phase <= PH_RUN;
                    end
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

    // R8: position counters stay inside the frame
    assert_pos_range_R8: assert property (@(posedge clk) disable iff (rst)
        (col <= COL_LAST) && (row <= ROW_LAST));

    // R8: the frame wraps to (0,0) after its last pixel
    assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && col == COL_LAST && row == ROW_LAST) |=> (col == '0 && row == '0));

    // R4: a window is flagged only in the run phase
    assert_fill_no_window_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FILL && accept) |=> !win_vld);
endmodule

// File: rtl/gauss_window.sv
module gauss_window #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          shift_en,
    input  logic [PIX_W-1:0]              pix,
    output logic [2:0][2:0][PIX_W-1:0]    win    // [row: 0 oldest][col: 0 oldest]
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0][PIX_W-1:0] line_in;
    logic [N_LINES-1:0][PIX_W-1:0] line_out;
    logic [2:0][PIX_W-1:0]         col_new;

    assign line_in[0] = pix;
    assign line_in[1] = line_out[0];

    // Line stores: each one image row deep, chained
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [PIX_W-1:0] taps [IMG_W];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < IMG_W; k++) taps[k] <= '0;
            end else if (shift_en) begin
                taps[0] <= line_in[g];
                for (int k = 1; k < IMG_W; k++) taps[k] <= taps[k-1];
            end
        end
        assign line_out[g] = taps[IMG_W-1];
    end

    // Newest column of the window: two rows up, one row up, current
    assign col_new[0] = line_out[1];
    assign col_new[1] = line_out[0];
    assign col_new[2] = pix;

    for (genvar r = 0; r < 3; r++) begin : g_winrow
        always_ff @(posedge clk) begin
            if (rst) begin
                win[r] <= '0;
            end else if (shift_en) begin
                win[r][0] <= win[r][1];
                win[r][1] <= win[r][2];
                win[r][2] <= col_new[r];
            end
        end
    end

    // R7: a cycle without an accepted pixel leaves the window untouched
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(win));
endmodule

// File: rtl/gauss_rowsum.sv
module gauss_rowsum #(
    parameter int PIX_W  = 8,
    parameter bit CENTER = 1'b0
) (
    input  logic [PIX_W-1:0] left,
    input  logic [PIX_W-1:0] mid,
    input  logic [PIX_W-1:0] right,
    output logic [PIX_W+2:0] sum
);
    localparam int BASE_W = PIX_W + 2;

    logic [BASE_W-1:0] base;

    // weights 1,2,1 via one shift and two adds
    assign base = BASE_W'(left) + {1'b0, mid, 1'b0} + BASE_W'(right);

    if (CENTER) begin : g_center
        assign sum = {base, 1'b0};          // weights 2,4,2
    end else begin : g_outer
        assign sum = {1'b0, base};
    end
endmodule

// File: rtl/gauss3x3_stream.sv
module gauss3x3_stream
    import gauss_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 10,
    parameter int IMG_H = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam int ROW_SUM_W = PIX_W + 3;
    localparam int ACC_W     = PIX_W + KERNEL_SHIFT;
    localparam int COL_W     = $clog2(IMG_W);
    localparam int ROW_W     = $clog2(IMG_H);

    logic                          accept;
    logic [2:0][2:0][PIX_W-1:0]    win;
    logic [2:0][ROW_SUM_W-1:0]     row_sum;
    logic [2:0][ROW_SUM_W-1:0]     row_sum_q;
    logic [ACC_W-1:0]              acc;
    logic [ACC_W-1:0]              acc_rnd;
    logic [COL_W-1:0]              col;
    logic [ROW_W-1:0]              row;
    logic                          win_vld;
    logic                          sum_vld;
    logic                          out_vld;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    gauss_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .col     (col),
        .row     (row),
        .win_vld (win_vld),
        .sum_vld (sum_vld),
        .out_vld (out_vld)
    );

    gauss_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .pix      (in_pix),
        .win      (win)
    );

    // Three row units; the middle one uses the doubled weights
    for (genvar r = 0; r < 3; r++) begin : g_rows
        gauss_rowsum #(.PIX_W(PIX_W), .CENTER(r == 1)) u_row (
            .left  (win[r][0]),
            .mid   (win[r][1]),
            .right (win[r][2]),
            .sum   (row_sum[r])
        );
    end

    // Stage 1: register row sums
    always_ff @(posedge clk) begin
        if (rst) row_sum_q <= '0;
        else     row_sum_q <= row_sum;
    end

    // Stage 2: add, round, normalise
    assign acc     = ACC_W'(row_sum_q[0]) + ACC_W'(row_sum_q[1]) + ACC_W'(row_sum_q[2]);
    assign acc_rnd = acc + ACC_W'(ROUND_BIAS);

    always_ff @(posedge clk) begin
        if (rst) out_pix <= '0;
        else     out_pix <= acc_rnd[ACC_W-1:KERNEL_SHIFT];
    end

    assign out_valid = out_vld;

    // R6: weighted total never exceeds 16 x max pixel
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        32'(acc) <= max_weighted_sum(PIX_W));

    // R5: an output follows an accepted pixel by exactly two further edges
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 3));

    // R4: outputs come only from windows fully inside the frame
    assert_interior_only_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(row, 3) >= ROW_W'(2) && $past(col, 3) >= COL_W'(2)));

    // R5: valid pipeline advances one stage per cycle
    assert_valid_chain_R5: assert property (@(posedge clk) disable iff (rst)
        win_vld |=> sum_vld);

    // R2: ready is held whenever out of reset
    assert_ready_R2: assert property (@(posedge clk) disable iff (rst) in_ready);
endmodule

// File: tb/tb_gauss3x3_stream.sv
module tb_gauss3x3_stream;
    localparam int W = 10;
    localparam int H = 5;
    localparam int PER_FRAME = (W - 2) * (H - 2);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pix = 8'd0;
    logic       out_valid;
    logic [7:0] out_pix;

    gauss3x3_stream #(.PIX_W(8), .IMG_W(W), .IMG_H(H)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int exp_val [4096];
    int exp_due [4096];
    int wr = 0, rd = 0;
    int img [H][W];
    int mr = 0, mc = 0;
    int out_cnt = 0, last_out = -1, run = 0, max_run = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Model: store the pixel, compute the interior result it completes
    task automatic model_accept(input int p, input int due);
        int s;
        img[mr][mc] = p;
        if (mr >= 2 && mc >= 2) begin
            s = 0;
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    s += ((i == 1) ? 2 : 1) * ((j == 1) ? 2 : 1) * img[mr-2+i][mc-2+j];
            exp_val[wr] = (s + 8) / 16;
            exp_due[wr] = due;
            wr++;
        end
        if (mc == W - 1) begin
            mc = 0;
            mr = (mr == H - 1) ? 0 : mr + 1;
        end else begin
            mc++;
        end
    endtask

    task automatic send(input int p);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = 8'(p);
        model_accept(p, cyc + 3);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = 8'($urandom_range(0, 255));   // R7: garbage while idle
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) idle_cycle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready low in reset", int'(in_ready), 0);
        mr = 0; mc = 0; rd = wr;
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R2 ready after reset", int'(in_ready), 1);
    endtask

    // Monitor: value and exact due cycle of every output
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit expect_now;
            expect_now = (rd < wr) && (exp_due[rd] == cyc);
            if (out_valid != expect_now)
                chk(1'b0, "R5 out_valid timing", int'(out_valid), int'(expect_now));
            if (out_valid && expect_now) begin
                chk(int'(out_pix) == exp_val[rd], "R3 output value", int'(out_pix), exp_val[rd]);
                rd++;
            end
            if (out_valid) begin
                out_cnt++;
                last_out = int'(out_pix);
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            finish_run();
        end
    end

    initial begin
        // R1, R2: reset state
        do_reset();

        // R3, R4, R9: random frame at full rate
        out_cnt = 0; max_run = 0;
        for (int k = 0; k < H * W; k++) send($urandom_range(0, 255));
        drain();
        chk(out_cnt == PER_FRAME, "R4 outputs per frame", out_cnt, PER_FRAME);
        chk(max_run == W - 2, "R9 consecutive outputs per row", max_run, W - 2);

        // R3: ramp and checkerboard patterns
        out_cnt = 0;
        for (int k = 0; k < H * W; k++) send((k * 5) % 256);
        for (int k = 0; k < H * W; k++) send((((k / W) + (k % W)) % 2) * 255);
        drain();
        chk(out_cnt == 2 * PER_FRAME, "R3 pattern frames output count", out_cnt, 2 * PER_FRAME);

        // R6: saturating frames
        out_cnt = 0;
        for (int k = 0; k < H * W; k++) send(255);
        drain();
        chk(last_out == 255, "R6 all-255 frame", last_out, 255);
        for (int k = 0; k < H * W; k++) send(0);
        drain();
        chk(last_out == 0, "R6 all-0 frame", last_out, 0);

        // R7: random stalls with garbage data
        out_cnt = 0;
        for (int k = 0; k < H * W; k++) begin
            if ($urandom_range(0, 2) == 0) idle_cycle();
            send($urandom_range(0, 255));
        end
        drain();
        chk(out_cnt == PER_FRAME, "R7 stalled frame output count", out_cnt, PER_FRAME);

        // R8: three frames back to back
        out_cnt = 0;
        for (int k = 0; k < 3 * H * W; k++) send($urandom_range(0, 255));
        drain();
        chk(out_cnt == 3 * PER_FRAME, "R8 back-to-back output count", out_cnt, 3 * PER_FRAME);

        // R1: reset in mid-frame, then a fresh full frame
        for (int k = 0; k < 2 * W + 5; k++) send($urandom_range(0, 255));
        do_reset();
        out_cnt = 0;
        for (int k = 0; k < H * W; k++) send($urandom_range(0, 255));
        drain();
        chk(out_cnt == PER_FRAME, "R1 frame after mid-frame reset", out_cnt, PER_FRAME);
        chk(rd == wr, "R5 all expected outputs seen", rd, wr);

        finish_run();
    end
endmodule